// File: doc/BRIEF.md
# Serial Flash Status Register and Write-Protect Controller

This block holds the status byte of a serial flash model and answers the status-read command on the serial slave pins. It also decides whether write-status, page-program, sector-erase and bulk-erase requests may proceed. The serial pins are oversampled by the system clock, so `sck`, `cs_n` and `si` are treated as slow data inputs. The serial clock must stay at each level for at least four system clocks. Serial-out is written as a data bit `so` plus an enable `so_oe`. When `so_oe` is 0, the pin is high-impedance.

After the command byte, the status byte streams out repeatedly until chip select rises. The status byte is sampled again at the start of every output byte. Bit layout: bit 7 is the status-write disable, bits 6..5 are zero, bits 4..2 are the three block-protect bits, bit 1 is the write-enable latch and bit 0 is busy. The rest of the flash model sets and clears busy and the write-enable latch through sideband strobes. It submits operation requests one cycle at a time and receives a registered accept or reject one cycle later. The non-volatile bits are plain registers that reset to zero.

Top module: `spi_stat_ctrl`

## Requirements
- R1: The status-read command is opcode 0x05. It is shifted in MSB first on `si`, sampled on rising `sck` edges while `cs_n` is low. `so_oe` stays 0 during the eight command bits.
- R2: After the eighth rising edge of a 0x05 command, each falling `sck` edge drives the next status bit MSB first on `so` with `so_oe`=1, within two system clocks. The status layout is {disable, 0, 0, protect[2:0], wel, busy}.
- R3: While `cs_n` stays low, the status byte repeats without a gap. Each repetition samples the status at its first bit, so a busy change in mid-byte appears in the following byte.
- R4: Raising `cs_n` forces `so_oe` to 0 within two system clocks and aborts a partial command with no effect. The next transaction decodes normally. Any opcode other than 0x05 leaves `so_oe` at 0 for the rest of the transaction.
- R5: After reset, `stat_byte` is 0x00. A set strobe for busy or wel takes effect in the next cycle. A clear strobe in the same cycle wins over the set strobe.
- R6: A cycle with `op_valid` high is answered by `op_ack`=1 in the next cycle, with `op_grant` giving the decision. `op_ack` is 0 in every other cycle. `op_kind` encodes 0 = write status, 1 = page program, 2 = sector erase, 3 = bulk erase.
- R7: Every request is rejected while the write-enable latch is 0.
- R8: A granted write-status request loads the disable bit from `op_wdata[7]` and the protect bits from `op_wdata[4:2]`. A write-status request is rejected while the disable bit is 1 and `wp_n` is 0, and in that state the disable and protect bits do not change.
- R9: Page program and sector erase are rejected when `op_addr` lies in the protected region. Protect value 0 guards nothing and 7 guards the whole array. A value k from 1 to 6 guards the addresses whose top 7-k bits are all ones, so the guarded region is 1/64 of the array at k=1 and doubles with each step.
- R10: Bulk erase is granted only when all three protect bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock (mode 0) |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out value |
| so_oe | output | 1 | Serial data out enable (0 = high-impedance) |
| wp_n | input | 1 | Write-protect pin, active low |
| wip_set | input | 1 | Set busy bit |
| wip_clr | input | 1 | Clear busy bit |
| wel_set | input | 1 | Set write-enable latch |
| wel_clr | input | 1 | Clear write-enable latch |
| op_valid | input | 1 | Operation request strobe |
| op_kind | input | 2 | Operation type (encoding in R6) |
| op_addr | input | ADDR_W | Target address for program or sector erase |
| op_wdata | input | 8 | New status value for write status |
| op_ack | output | 1 | Decision valid, one cycle after request |
| op_grant | output | 1 | Request accepted |
| stat_byte | output | 8 | Current status byte |

## Verification
The status register has no hidden copy, so a wrong bit shows on `stat_byte` in the cycle after the strobe or request that caused it. It shows on `so` at the start of the next status byte on the serial side. A wrong protect decode or a wrong write-enable gate shows in `op_grant` in the single cycle after the request, together with a status that does or does not change. A wrong bit counter or phase shows within one serial bit time as `so_oe` at the wrong level, a shifted MSB, or a missing repetition at a byte boundary.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

  localparam logic [7:0] RD_STAT_CODE = 8'h05;

  typedef enum logic [1:0] {
    OP_WRSTAT = 2'd0,
    OP_PROG   = 2'd1,
    OP_SECT   = 2'd2,
    OP_BULK   = 2'd3
  } op_kind_e;

  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_SEND = 2'd1,
    PH_SKIP = 2'd2
  } ser_phase_e;

  typedef struct packed {
    logic       srwd;
    logic [1:0] zero;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;

endpackage

// File: rtl/region_prot.sv
module region_prot #(
  parameter int ADDR_W = 20
) (
  input  logic [2:0]        bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP_BITS = 6;

  always_comb begin
    if (bp == 3'd0) begin
      hit = 1'b0;
    end else begin
      hit = 1'b1;
      for (int i = 0; i < TOP_BITS; i++) begin
        if (i < (7 - int'(bp))) hit = hit & addr[ADDR_W-1-i];
      end
    end
  end
endmodule

// File: rtl/stat_regs.sv
module stat_regs
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              wip_set,
  input  logic              wip_clr,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_wdata,
  output logic              op_ack,
  output logic              op_grant,
  output stat_t             stat
);
  stat_t    stat_nxt;
  op_kind_e kind;
  logic     prot_hit;
  logic     grant_c;
  logic     ack_nxt, grant_nxt;
  logic     unused_wd;

  assign kind      = op_kind_e'(op_kind);
  assign unused_wd = ^{op_wdata[6:5], op_wdata[1:0]};

  region_prot #(.ADDR_W(ADDR_W)) u_prot (
    .bp   (stat.bp),
    .addr (op_addr),
    .hit  (prot_hit)
  );

  always_comb begin
    grant_c = 1'b0;
    if (stat.wel) begin
      unique case (kind)
        OP_WRSTAT: grant_c = !(stat.srwd && !wp_n);
        OP_PROG,
        OP_SECT:   grant_c = !prot_hit;
        OP_BULK:   grant_c = (stat.bp == 3'd0);
        default:   grant_c = 1'b0;
      endcase
    end
  end

  always_comb begin
    stat_nxt      = stat;
    stat_nxt.zero = 2'b00;
    if (wip_clr)      stat_nxt.wip = 1'b0;
    else if (wip_set) stat_nxt.wip = 1'b1;
    if (wel_clr)      stat_nxt.wel = 1'b0;
    else if (wel_set) stat_nxt.wel = 1'b1;
    if (op_valid && grant_c && kind == OP_WRSTAT) begin
      stat_nxt.srwd = op_wdata[7];
      stat_nxt.bp   = op_wdata[4:2];
    end
    ack_nxt   = op_valid;
    grant_nxt = op_valid && grant_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= '0;
      op_ack   <= 1'b0;
      op_grant <= 1'b0;
    end else begin
      stat     <= stat_nxt;
      op_ack   <= ack_nxt;
      op_grant <= grant_nxt;
    end
  end
endmodule

// File: rtl/spi_stat_shifter.sv
module spi_stat_shifter
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic [7:0] stat,
  output logic       so,
  output logic       so_oe
);
  logic       cs_q, sck_q, sck_d, si_q;
  ser_phase_e phase, phase_nxt;
  logic [2:0] cnt, cnt_nxt;
  logic [7:0] sh, sh_nxt;
  logic [7:0] out_b, out_nxt;
  logic       so_nxt, oe_nxt;
  logic       rise, fall;

  assign rise = sck_q & ~sck_d & ~cs_q;
  assign fall = ~sck_q & sck_d & ~cs_q;

  always_comb begin
    phase_nxt = phase;
    cnt_nxt   = cnt;
    sh_nxt    = sh;
    out_nxt   = out_b;
    so_nxt    = so;
    oe_nxt    = so_oe;
    if (cs_q) begin
      phase_nxt = PH_CMD;
      cnt_nxt   = 3'd0;
      oe_nxt    = 1'b0;
    end else begin
      unique case (phase)
        PH_CMD: if (rise) begin
          sh_nxt  = {sh[6:0], si_q};
          cnt_nxt = cnt + 3'd1;
          if (cnt == 3'd7)
            phase_nxt = (sh_nxt == RD_STAT_CODE) ? PH_SEND : PH_SKIP;
        end
        PH_SEND: if (fall) begin
          if (cnt == 3'd0) begin
            out_nxt = stat;
            so_nxt  = stat[7];
          end else begin
            so_nxt  = out_b[3'd7 - cnt];
          end
          oe_nxt  = 1'b1;
          cnt_nxt = cnt + 3'd1;
        end
        default: oe_nxt = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      si_q  <= 1'b0;
    end else begin
      cs_q  <= cs_n;
      sck_q <= sck;
      sck_d <= sck_q;
      si_q  <= si;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
      sh    <= '0;
      out_b <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
      sh    <= sh_nxt;
      out_b <= out_nxt;
      so    <= so_nxt;
      so_oe <= oe_nxt;
    end
  end
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              so_oe,
  input  logic              wp_n,
  input  logic              wip_set,
  input  logic              wip_clr,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [7:0]        op_wdata,
  output logic              op_ack,
  output logic              op_grant,
  output logic [7:0]        stat_byte
);
  logic  rst_meta, rst_n_s;
  stat_t stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  stat_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wp_n     (wp_n),
    .wip_set  (wip_set),
    .wip_clr  (wip_clr),
    .wel_set  (wel_set),
    .wel_clr  (wel_clr),
    .op_valid (op_valid),
    .op_kind  (op_kind),
    .op_addr  (op_addr),
    .op_wdata (op_wdata),
    .op_ack   (op_ack),
    .op_grant (op_grant),
    .stat     (stat)
  );

  assign stat_byte = stat;

  spi_stat_shifter u_ser (
    .clk   (clk),
    .rst_n (rst_n_s),
    .cs_n  (cs_n),
    .sck   (sck),
    .si    (si),
    .stat  (stat_byte),
    .so    (so),
    .so_oe (so_oe)
  );
endmodule

// File: rtl/spi_stat_ctrl_chk.sv
module spi_stat_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       so_oe,
  input logic       wp_n,
  input logic       wip_clr,
  input logic       wel_clr,
  input logic       op_valid,
  input logic [1:0] op_kind,
  input logic       op_ack,
  input logic       op_grant,
  input logic [7:0] stat_byte
);
  assert_idle_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n, 2) |-> !so_oe);

  assert_wip_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wip_clr |=> !stat_byte[0]);

  assert_wel_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !stat_byte[1]);

  assert_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> op_ack);

  assert_no_stray_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !op_ack);

  assert_wel_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ack && op_grant) |-> $past(stat_byte[1]));

  assert_hw_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_byte[7]) && !$past(wp_n)) |-> (stat_byte[7:2] == $past(stat_byte[7:2])));

  assert_bulk_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_ack && op_grant && $past(op_kind) == 2'd3) |-> ($past(stat_byte[4:2]) == 3'd0));
endmodule

bind spi_stat_ctrl spi_stat_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .cs_n      (cs_n),
  .so_oe     (so_oe),
  .wp_n      (wp_n),
  .wip_clr   (wip_clr),
  .wel_clr   (wel_clr),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_ack    (op_ack),
  .op_grant  (op_grant),
  .stat_byte (stat_byte)
);

// File: tb/test_spi_stat_ctrl.sv
`timescale 1ns/1ps
module test_spi_stat_ctrl;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic wp_n = 1'b1;
  logic wip_set = 1'b0, wip_clr = 1'b0, wel_set = 1'b0, wel_clr = 1'b0;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [AW-1:0] op_addr = '0;
  logic [7:0] op_wdata = 8'h00;
  logic op_ack, op_grant;
  logic [7:0] stat_byte;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // behavioural reference state
  bit m_srwd, m_wel, m_wip;
  int m_bp;
  bit m_ack, m_grant;

  always #2 clk = ~clk;

  spi_stat_ctrl #(.ADDR_W(AW)) i_spi_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .so(so), .so_oe(so_oe),
    .wp_n(wp_n), .wip_set(wip_set), .wip_clr(wip_clr), .wel_set(wel_set), .wel_clr(wel_clr),
    .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr), .op_wdata(op_wdata),
    .op_ack(op_ack), .op_grant(op_grant), .stat_byte(stat_byte)
  );

  function automatic int m_stat();
    return (int'(m_srwd) << 7) | (m_bp << 2) | (int'(m_wel) << 1) | int'(m_wip);
  endfunction

  function automatic bit in_region(int bp, int addr);
    int n;
    if (bp == 0) return 1'b0;
    if (bp == 7) return 1'b1;
    n = 7 - bp;
    return (addr >> (AW - n)) == ((1 << n) - 1);
  endfunction

  function automatic bit m_decide(int kind, int addr);
    if (!m_wel) return 1'b0;
    case (kind)
      0: return !(m_srwd && !wp_n);
      1, 2: return !in_region(m_bp, addr);
      default: return m_bp == 0;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference model, advanced on every clock
  always @(posedge clk) begin
    if (!rst_n) begin
      m_srwd = 0; m_wel = 0; m_wip = 0; m_bp = 0; m_ack = 0; m_grant = 0;
    end else begin
      bit g;
      g = m_decide(int'(op_kind), int'(op_addr));
      m_ack = op_valid;
      m_grant = op_valid && g;
      if (op_valid && g && op_kind == 2'd0) begin
        m_srwd = op_wdata[7];
        m_bp = int'(op_wdata[4:2]);
      end
      if (wip_clr) m_wip = 0; else if (wip_set) m_wip = 1;
      if (wel_clr) m_wel = 0; else if (wel_set) m_wel = 1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5 status", int'(stat_byte), m_stat());
      chk("R6 ack", int'(op_ack), int'(m_ack));
      chk("R7 grant", int'(op_grant), int'(m_grant));
    end
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: wip_set = 1; 1: wip_clr = 1; 2: wel_set = 1; 3: wel_clr = 1;
      default: begin wel_set = 1; wel_clr = 1; end
    endcase
    @(negedge clk);
    wip_set = 0; wip_clr = 0; wel_set = 0; wel_clr = 0;
  endtask

  task automatic do_op(input int kind, input int addr, input int wd, input string req, input bit exp_g);
    @(negedge clk);
    op_valid = 1; op_kind = 2'(kind); op_addr = AW'(addr); op_wdata = 8'(wd);
    @(negedge clk);
    op_valid = 0;
    chk(req, int'(op_grant), int'(exp_g));
  endtask

  task automatic spi_xfer(input logic [7:0] code, input int nbytes, input int abort_at, input bit poke);
    int expb;
    bit aborted;
    aborted = 0;
    @(negedge clk);
    cs_n = 0; sck = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      if (i == abort_at) begin aborted = 1; break; end
      si = code[7-i];
      repeat (4) @(negedge clk);
      chk("R1 hiz during command", int'(so_oe), 0);
      sck = 1;
      repeat (4) @(negedge clk);
      sck = 0;
    end
    if (!aborted) begin
      for (int b = 0; b < nbytes; b++) begin
        for (int k = 0; k < 8; k++) begin
          if (k == 0) expb = m_stat();
          repeat (2) @(negedge clk);
          if (poke && b == 0 && k == 3) begin
            wip_set = 1; @(negedge clk); wip_set = 0; @(negedge clk);
          end else begin
            repeat (2) @(negedge clk);
          end
          if (code == 8'h05) begin
            chk("R2 so_oe", int'(so_oe), 1);
            chk("R3 status bit", int'(so), (expb >> (7 - k)) & 1);
          end else begin
            chk("R4 other opcode hiz", int'(so_oe), 0);
          end
          sck = 1;
          repeat (4) @(negedge clk);
          sck = 0;
        end
      end
    end
    cs_n = 1;
    repeat (4) @(negedge clk);
    chk("R4 hiz after cs high", int'(so_oe), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R5 reset status", int'(stat_byte), 0);
    chk("R4 reset hiz", int'(so_oe), 0);

    spi_xfer(8'h05, 2, 99, 0);                         // R1 R2 R3 zero status
    do_op(0, 0, 8'h9C, "R7 write without wel", 0);
    strobe(2);
    chk("R5 wel set", int'(stat_byte), 8'h02);
    do_op(0, 0, 8'h9F, "R8 write status", 1);
    chk("R8 loaded bits", int'(stat_byte), 8'h9E);
    spi_xfer(8'h05, 3, 99, 1);                         // R3 busy shows in byte 2
    strobe(1);
    do_op(2, 0, 0, "R9 sector erase bp7", 0);
    wp_n = 0;
    do_op(0, 0, 8'h00, "R8 hw protect rejects", 0);
    chk("R8 frozen", int'(stat_byte), 8'h9E);
    wp_n = 1;
    do_op(0, 0, 8'h18, "R8 write after wp released", 1);
    do_op(1, 20'h80000, 0, "R9 bp6 upper half", 0);
    do_op(1, 20'h7FFFF, 0, "R9 bp6 lower half", 1);
    do_op(2, 20'hFFFFF, 0, "R9 bp6 sector top", 0);
    do_op(3, 0, 0, "R10 bulk with bp6", 0);
    do_op(0, 0, 8'h04, "R8 write bp1", 1);
    do_op(1, 20'hFC000, 0, "R9 bp1 top 1/64", 0);
    do_op(1, 20'hF8000, 0, "R9 bp1 below top", 1);
    do_op(0, 0, 8'h00, "R8 clear bp", 1);
    do_op(3, 0, 0, "R10 bulk with bp0", 1);
    strobe(3);
    do_op(1, 0, 0, "R7 program without wel", 0);
    strobe(2);
    strobe(4);
    chk("R5 clear wins", int'(stat_byte), 8'h00);
    strobe(0);
    strobe(0);
    spi_xfer(8'h05, 0, 4, 0);                          // R4 abort mid-command
    spi_xfer(8'h05, 1, 99, 0);                         // busy read after abort
    spi_xfer(8'h06, 2, 99, 0);                         // R4 other opcode
    strobe(1);
    spi_xfer(8'h05, 1, 99, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule